// File: doc/BRIEF.md
# Host Parallel Port

This block links an external host to an internal processor bus through an 8-bit parallel port. Each direction has one single-entry buffer. The host-to-core buffer is called the inbox. The core-to-host buffer is called the outbox. Each buffer has a full flag. Both flags appear on pins and in a status word that the host can read.

A host access counts only while the select input is high. In normal mode, a low address bit picks the data buffer and a high address bit picks the status word. The host read and write strobes are level inputs, sampled on the block clock. An access takes place on the first clock at which a strobe is seen high.

An alternate printer-style mode is also provided. In this mode the host read strobe is ignored and the write strobe alone deposits a byte, whatever the address bit. A busy output then holds the host off until the core has taken the byte.

Top module: `hpp_port`

## Requirements
- R1: While reset is asserted, and after it is released, the inbox flag, the outbox flag, busy and the host drive enable are all low.
- R2: With the select input low, host strobes have no effect: no flag changes and the data bus is not driven.
- R3: In normal mode, a host write with address 0 into an empty inbox stores the byte, which appears on `cpu_rdata`. The inbox flag is high from the clock after the strobe is sampled.
- R4: A `cpu_rd` pulse empties the inbox and drops busy on the next clock.
- R5: A `cpu_wr` pulse loads `cpu_wdata` into the outbox and raises the outbox flag on the next clock.
- R6: A host read with address 0 in normal mode returns the outbox byte and clears the outbox flag. `hp_doe` rises one clock after the strobe is first sampled. It falls on the first clock that samples the strobe low.
- R7: A host read with address 1 returns the status word: bit 0 is the inbox flag, bit 1 the outbox flag, bit 2 the overrun flag, and all other bits are 0. This read clears the overrun flag.
- R8: A host write to a full inbox is dropped, leaving `cpu_rdata` unchanged, and sets the sticky overrun flag.
- R9: In printer mode, a write strobe stores the byte whatever the address bit. Busy is high from the next clock until a `cpu_rd` pulse.
- R10: In printer mode, the host read strobe is ignored: `hp_doe` stays low and the outbox flag is kept.
- R11: In normal mode, a host write with address 1 is ignored and leaves the inbox empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cent_mode | input | 1 | Printer-style mode when high |
| hp_sel | input | 1 | Host select, active high |
| hp_addr | input | 1 | 0 selects data, 1 selects status |
| hp_rd | input | 1 | Host read strobe, level, active high |
| hp_wr | input | 1 | Host write strobe, level, active high |
| hp_din | input | DW | Host write data |
| hp_dout | output | DW | Host read data, zero when not driven |
| hp_doe | output | 1 | Host data bus drive enable |
| ibf_pin | output | 1 | Inbox full flag |
| obf_pin | output | 1 | Outbox full flag |
| busy | output | 1 | Printer-mode busy |
| cpu_wr | input | 1 | Core write pulse to the outbox |
| cpu_wdata | input | DW | Core write data |
| cpu_rd | input | 1 | Core read pulse that consumes the inbox |
| cpu_rdata | output | DW | Inbox contents |

## Verification
The bench builds the port with the default width of 8. At that width, the three status flags sit in the low bits of a byte and the upper five bits can be checked to be zero. Data patterns of all ones, all zeros and mixed bytes show that the full byte width is stored and returned. The bench also drives several edge cases: a dropped write into a full inbox, the overrun flag cleared by a status read, writes to the status address, reads and writes with select low, and strobes in printer mode. Each of these is followed by a check of the flags and of the bytes that come back.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  localparam int ST_IBF  = 0;
  localparam int ST_OBF  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_BITS = 3;

  // Packs the flags into the low bits of the status word.
  function automatic logic [ST_BITS-1:0] status_bits(input logic ibf, input logic obf,
                                                     input logic ovr);
    logic [ST_BITS-1:0] s;
    s = '0;
    s[ST_IBF] = ibf;
    s[ST_OBF] = obf;
    s[ST_OVR] = ovr;
    return s;
  endfunction

  function automatic logic rise(input logic now, input logic prev);
    return now & ~prev;
  endfunction
endpackage

// File: rtl/hpp_edge.sv
module hpp_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  import hpp_pkg::*;
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[i] <= 1'b0;
      else        prev[i] <= lvl[i];
    end
    assign rise[i] = hpp_pkg::rise(lvl[i], prev[i]);
  end
endmodule

// File: rtl/hpp_inbuf.sv
module hpp_inbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ev,
  input  logic [DW-1:0] din,
  input  logic          consume,
  input  logic          cent_mode,
  input  logic          ovr_clr,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          busy,
  output logic          ovr
);
  logic accept, drop;
  assign accept = wr_ev & ~full;
  assign drop   = wr_ev & full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
      busy <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (accept) data <= din;
      full <= accept | (full & ~consume);
      busy <= (wr_ev & cent_mode) | (busy & ~consume);
      ovr  <= drop | (ovr & ~ovr_clr);
    end
  end
endmodule

// File: rtl/hpp_outbuf.sv
module hpp_outbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          rd_data_ev,
  input  logic          rd_stat_ev,
  input  logic [DW-1:0] stat_word,
  input  logic          rd_level,
  input  logic          cent_mode,
  output logic          full,
  output logic [DW-1:0] dout,
  output logic          doe
);
  logic [DW-1:0] buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      full  <= 1'b0;
      dout  <= '0;
      doe   <= 1'b0;
    end else begin
      if (load) buf_q <= load_data;
      full <= load | (full & ~rd_data_ev);
      if (rd_data_ev)      dout <= buf_q;
      else if (rd_stat_ev) dout <= stat_word;
      if (cent_mode || !rd_level)      doe <= 1'b0;
      else if (rd_data_ev || rd_stat_ev) doe <= 1'b1;
    end
  end
endmodule

// File: rtl/hpp_port.sv
module hpp_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cent_mode,
  input  logic          hp_sel,
  input  logic          hp_addr,
  input  logic          hp_rd,
  input  logic          hp_wr,
  input  logic [DW-1:0] hp_din,
  output logic [DW-1:0] hp_dout,
  output logic          hp_doe,
  output logic          ibf_pin,
  output logic          obf_pin,
  output logic          busy,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  output logic [DW-1:0] cpu_rdata
);
  import hpp_pkg::*;

  localparam int STROBES = 2;
  localparam int S_RD = 0;
  localparam int S_WR = 1;

  logic [STROBES-1:0] strobe_rise;
  logic host_wr_ev, host_rd_data_ev, host_rd_stat_ev;
  logic ovr_flag;
  logic [DW-1:0] stat_word, dout_q;

  hpp_edge #(.N(STROBES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({hp_wr, hp_rd}),
    .rise (strobe_rise)
  );

  // Named host events
  assign host_wr_ev      = strobe_rise[S_WR] & hp_sel & (cent_mode | ~hp_addr);
  assign host_rd_data_ev = strobe_rise[S_RD] & hp_sel & ~cent_mode & ~hp_addr;
  assign host_rd_stat_ev = strobe_rise[S_RD] & hp_sel & ~cent_mode & hp_addr;

  assign stat_word = DW'(status_bits(ibf_pin, obf_pin, ovr_flag));

  hpp_inbuf #(.DW(DW)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ev    (host_wr_ev),
    .din      (hp_din),
    .consume  (cpu_rd),
    .cent_mode(cent_mode),
    .ovr_clr  (host_rd_stat_ev),
    .data     (cpu_rdata),
    .full     (ibf_pin),
    .busy     (busy),
    .ovr      (ovr_flag)
  );

  hpp_outbuf #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cpu_wr),
    .load_data (cpu_wdata),
    .rd_data_ev(host_rd_data_ev),
    .rd_stat_ev(host_rd_stat_ev),
    .stat_word (stat_word),
    .rd_level  (hp_rd),
    .cent_mode (cent_mode),
    .full      (obf_pin),
    .dout      (dout_q),
    .doe       (hp_doe)
  );

  assign hp_dout = hp_doe ? dout_q : '0;
endmodule

// File: rtl/hpp_port_chk.sv
module hpp_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cent_mode,
  input logic          hp_sel,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic          ibf_pin,
  input logic          obf_pin,
  input logic          busy,
  input logic          hp_doe,
  input logic [DW-1:0] cpu_rdata,
  input logic          host_wr_ev,
  input logic          host_rd_data_ev,
  input logic          ovr_flag
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!ibf_pin && !obf_pin && !busy && !hp_doe));

  p_nosel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hp_sel && !cpu_rd && !cpu_wr) |=> ($stable(ibf_pin) && $stable(obf_pin)));

  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_ev && !ibf_pin) |=> ibf_pin);

  p_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !host_wr_ev) |=> (!ibf_pin && !busy));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> obf_pin);

  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_data_ev && !cpu_wr) |=> !obf_pin);

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_ev && ibf_pin) |=> (ovr_flag && $stable(cpu_rdata)));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cpu_rd) |=> busy);

  p_cent_nodrive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cent_mode |=> !hp_doe);
endmodule

bind hpp_port hpp_port_chk #(.DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cent_mode      (cent_mode),
  .hp_sel         (hp_sel),
  .cpu_rd         (cpu_rd),
  .cpu_wr         (cpu_wr),
  .ibf_pin        (ibf_pin),
  .obf_pin        (obf_pin),
  .busy           (busy),
  .hp_doe         (hp_doe),
  .cpu_rdata      (cpu_rdata),
  .host_wr_ev     (host_wr_ev),
  .host_rd_data_ev(host_rd_data_ev),
  .ovr_flag       (ovr_flag)
);

// File: tb/test_hpp_port.sv
`timescale 1ns/1ps
module test_hpp_port;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cent_mode = 1'b0, hp_sel = 1'b0, hp_addr = 1'b0, hp_rd = 1'b0, hp_wr = 1'b0;
  logic [DW-1:0] hp_din = '0, cpu_wdata = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [DW-1:0] hp_dout, cpu_rdata;
  logic hp_doe, ibf_pin, obf_pin, busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  hpp_port #(.DW(DW)) i_hpp_port (
    .clk(clk), .rst_n(rst_n), .cent_mode(cent_mode), .hp_sel(hp_sel), .hp_addr(hp_addr),
    .hp_rd(hp_rd), .hp_wr(hp_wr), .hp_din(hp_din), .hp_dout(hp_dout), .hp_doe(hp_doe),
    .ibf_pin(ibf_pin), .obf_pin(obf_pin), .busy(busy), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected byte when the port starts driving.
  logic doe_prev = 1'b0;
  always @(negedge clk) begin
    if (hp_doe && !doe_prev) begin
      if (exp_q.size() == 0) chk("R6 unexpected drive", 1, 0);
      else chk(tag_q.pop_front(), hp_dout, exp_q.pop_front());
    end
    doe_prev <= hp_doe;
  end

  task automatic host_write(input logic sel, input logic addr, input logic [DW-1:0] d);
    @(negedge clk);
    hp_sel = sel; hp_addr = addr; hp_din = d; hp_wr = 1'b1;
    @(negedge clk);
    hp_wr = 1'b0; hp_sel = 1'b0;
  endtask

  // Pushes the expected byte, strobes, then checks the drive window.
  task automatic host_read(input logic addr, input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    hp_sel = 1'b1; hp_addr = addr; hp_rd = 1'b1;
    @(negedge clk);
    chk("R6 drive after one clock", hp_doe, 1);
    hp_rd = 1'b0; hp_sel = 1'b0;
    @(negedge clk);
    chk("R6 release", hp_doe, 0);
  endtask

  task automatic cpu_write(input logic [DW-1:0] d);
    @(negedge clk);
    cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read();
    @(negedge clk);
    cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ibf in reset", ibf_pin, 0);
    chk("R1 obf in reset", obf_pin, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 doe after reset", hp_doe, 0);

    // R2: unselected write and read
    host_write(1'b0, 1'b0, 8'h5A);
    chk("R2 ibf with select low", ibf_pin, 0);
    cpu_write(8'hC3);
    chk("R5 obf set", obf_pin, 1);
    @(negedge clk);
    hp_rd = 1'b1;
    @(negedge clk);
    chk("R2 no drive with select low", hp_doe, 0);
    hp_rd = 1'b0;
    @(negedge clk);
    chk("R2 obf kept", obf_pin, 1);

    host_read(1'b1, 8'h02, "R7 status obf only");
    host_read(1'b0, 8'hC3, "R6 data read");
    chk("R6 obf cleared", obf_pin, 0);

    host_write(1'b1, 1'b0, 8'h5A);
    chk("R3 ibf set", ibf_pin, 1);
    chk("R3 data stored", cpu_rdata, 8'h5A);
    host_read(1'b1, 8'h01, "R7 status ibf only");

    host_write(1'b1, 1'b0, 8'h77);
    chk("R8 dropped write", cpu_rdata, 8'h5A);
    host_read(1'b1, 8'h05, "R8 overrun reported");
    host_read(1'b1, 8'h01, "R7 overrun cleared by status read");

    cpu_read();
    chk("R4 ibf cleared", ibf_pin, 0);
    host_write(1'b1, 1'b1, 8'h11);
    chk("R11 status write ignored", ibf_pin, 0);

    host_write(1'b1, 1'b0, 8'hFF);
    chk("R3 all ones", cpu_rdata, 8'hFF);
    cpu_read();
    host_write(1'b1, 1'b0, 8'h00);
    chk("R3 all zeros flag", ibf_pin, 1);
    chk("R3 all zeros data", cpu_rdata, 8'h00);
    cpu_read();
    cpu_write(8'hA5);
    host_read(1'b0, 8'hA5, "R6 second pattern");

    // Printer mode
    cent_mode = 1'b1;
    host_write(1'b1, 1'b1, 8'h3C);
    chk("R9 busy high", busy, 1);
    chk("R9 byte stored", cpu_rdata, 8'h3C);
    cpu_write(8'h99);
    @(negedge clk);
    hp_sel = 1'b1; hp_rd = 1'b1;
    @(negedge clk);
    chk("R10 no drive", hp_doe, 0);
    hp_rd = 1'b0; hp_sel = 1'b0;
    @(negedge clk);
    chk("R10 obf kept", obf_pin, 1);
    chk("R9 busy held", busy, 1);
    cpu_read();
    chk("R9 busy dropped", busy, 0);
    chk("R4 ibf empty", ibf_pin, 0);
    cent_mode = 1'b0;
    host_read(1'b0, 8'h99, "R6 read after mode exit");

    repeat (2) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule